// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and lets either one drive the other. Each side has its own capture register with its own clock. Every rising edge of that clock stores the bus value, whatever state the outputs are in. For each direction a select input chooses what the driving port sends. It can send the live value of the opposite bus, with no clock latency. It can also send the value held in that bus's capture register.

An active-low enable and a direction input decide which port drives, if either does. Every value that leaves the block is the bitwise inverse of its source. For synthesis, each bus is split into an input vector, an output vector and an output-enable vector. The enable vector is all ones when that port drives and all zeros when it does not.

The width and the output polarity are parameters. The shipped configuration is 8 bits wide with inverted outputs.

Top module: `regbus_xcvr`

## Requirements
- R1: The A register loads `a_in` on each rising edge of `clk_a`, and the B register loads `b_in` on each rising edge of `clk_b`. Each register is unaffected by the other clock, whether the edges are simultaneous or staggered.
- R2: Capture happens on every rising clock edge regardless of `oe_n`, `dir`, `sel_b_src` and `sel_a_src`, including while both ports are isolated.
- R3: While `oe_n` is 1, `a_oe` and `b_oe` are all zeros and `a_out` and `b_out` are all zeros, whatever `dir` and the selects are.
- R4: While `oe_n` is 0 and `dir` is 1, `b_oe` is all ones and `a_oe` is all zeros. While `oe_n` is 0 and `dir` is 0, `a_oe` is all ones and `b_oe` is all zeros. Each enable vector is only ever all zeros or all ones.
- R5: `a_oe` and `b_oe` are never non-zero at the same time.
- R6: When B drives with `sel_b_src` = 0, `b_out` equals `~a_in` in the same cycle with no clock. When A drives with `sel_a_src` = 0, `a_out` equals `~b_in` in the same way.
- R7: When B drives with `sel_b_src` = 1, `b_out` equals the inverse of the A register. When A drives with `sel_a_src` = 1, `a_out` equals the inverse of the B register.
- R8: In stored mode, a rising edge on the clock of the register that feeds the driving port puts the inverse of the newly captured value on that output directly after the edge.
- R9: An active-low asynchronous `rst_n` clears both registers to zero, so stored-mode outputs read all ones before any capture.
- R10: The select input of the port that is not driving has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Capture clock for the A register (rising edge) |
| clk_b | input | 1 | Capture clock for the B register (rising edge) |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| oe_n | input | 1 | Active-low output enable; 1 isolates both ports |
| dir | input | 1 | 1: B port drives; 0: A port drives |
| sel_b_src | input | 1 | Source for B outputs: 0 live A bus, 1 A register |
| sel_a_src | input | 1 | Source for A outputs: 0 live B bus, 1 B register |
| a_in | input | WIDTH | Value present on the A bus |
| b_in | input | WIDTH | Value present on the B bus |
| a_out | output | WIDTH | Value driven onto the A bus (zero when not driving) |
| a_oe | output | WIDTH | Per-bit drive enable for the A bus |
| b_out | output | WIDTH | Value driven onto the B bus (zero when not driving) |
| b_oe | output | WIDTH | Per-bit drive enable for the B bus |

## Verification
The capture checks are sampled on each register's own clock. They assume that `a_in` and `b_in` are stable across each rising edge of the matching clock. The bench meets this by changing bus values only while both clocks are low, well away from any edge. The output checks assume that `rst_n` is only released while both clocks are low. The bench holds the clocks low around reset and drives its capture pulses by hand. Simultaneous edges are produced in a single assignment so that both registers see the same instant.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
   typedef enum logic [1:0] {
      SIDE_NONE = 2'd0,
      SIDE_A    = 2'd1,
      SIDE_B    = 2'd2
   } drive_side_e;
endpackage

// File: rtl/regbus_capture.sv
module regbus_capture #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/regbus_drive_dec.sv
module regbus_drive_dec
   import regbus_pkg::*;
(
   input  logic        oe_n,
   input  logic        dir,
   output drive_side_e side
);
   always_comb begin
      if (oe_n)     side = SIDE_NONE;
      else if (dir) side = SIDE_B;
      else          side = SIDE_A;
   end
endmodule

// File: rtl/regbus_path.sv
module regbus_path #(
   parameter int WIDTH  = 8,
   parameter bit INVERT = 1'b1
) (
   input  logic             use_stored,
   input  logic             drive,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] out,
   output logic [WIDTH-1:0] oe
);
   logic [WIDTH-1:0] picked;
   logic [WIDTH-1:0] shaped;

   assign picked = use_stored ? stored : live;

   generate
      if (INVERT) begin : g_inv
         assign shaped = ~picked;
      end else begin : g_true
         assign shaped = picked;
      end
   endgenerate

   assign out = drive ? shaped : '0;
   assign oe  = {WIDTH{drive}};
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
   import regbus_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit INVERT_OUT = 1'b1
) (
   input  logic             clk_a,
   input  logic             clk_b,
   input  logic             rst_n,
   input  logic             oe_n,
   input  logic             dir,
   input  logic             sel_b_src,
   input  logic             sel_a_src,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("regbus_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] a_store;
   logic [WIDTH-1:0] b_store;
   drive_side_e      side;

   regbus_capture #(.WIDTH(WIDTH)) u_cap_a (
      .clk(clk_a), .rst_n(rst_n), .d(a_in), .q(a_store)
   );

   regbus_capture #(.WIDTH(WIDTH)) u_cap_b (
      .clk(clk_b), .rst_n(rst_n), .d(b_in), .q(b_store)
   );

   regbus_drive_dec u_dec (
      .oe_n(oe_n), .dir(dir), .side(side)
   );

   regbus_path #(.WIDTH(WIDTH), .INVERT(INVERT_OUT)) u_to_b (
      .use_stored(sel_b_src),
      .drive     (side == SIDE_B),
      .live      (a_in),
      .stored    (a_store),
      .out       (b_out),
      .oe        (b_oe)
   );

   regbus_path #(.WIDTH(WIDTH), .INVERT(INVERT_OUT)) u_to_a (
      .use_stored(sel_a_src),
      .drive     (side == SIDE_A),
      .live      (b_in),
      .stored    (b_store),
      .out       (a_out),
      .oe        (a_oe)
   );
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk_a,
   input logic             clk_b,
   input logic             rst_n,
   input logic             oe_n,
   input logic             dir,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] a_store,
   input logic [WIDTH-1:0] b_store,
   input logic [WIDTH-1:0] a_oe,
   input logic [WIDTH-1:0] b_oe,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] b_out
);
   AST_A_CAPTURE: assert property (@(posedge clk_a) disable iff (!rst_n)
      1'b1 |=> a_store == $past(a_in)); // R1

   AST_B_CAPTURE: assert property (@(posedge clk_b) disable iff (!rst_n)
      1'b1 |=> b_store == $past(b_in)); // R1

   AST_ISOLATED_CAPTURE: assert property (@(posedge clk_a) disable iff (!rst_n)
      oe_n |=> a_store == $past(a_in)); // R2

   AST_ISOLATE_QUIET: assert property (@(posedge clk_a) disable iff (!rst_n)
      oe_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0)); // R3

   AST_OE_WHOLE: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1)); // R4

   AST_DIR_B: assert property (@(posedge clk_a) disable iff (!rst_n)
      (!oe_n && dir) |-> (b_oe == '1 && a_oe == '0)); // R4

   AST_ONE_DRIVER: assert property (@(posedge clk_b) disable iff (!rst_n)
      !((|a_oe) && (|b_oe))); // R5

   AST_UNDRIVEN_ZERO: assert property (@(posedge clk_b) disable iff (!rst_n)
      (b_oe == '0) |-> b_out == '0); // R3
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
   .a_in(a_in), .b_in(b_in), .a_store(a_store), .b_store(b_store),
   .a_oe(a_oe), .b_oe(b_oe), .a_out(a_out), .b_out(b_out)
);

// File: tb/regbus_xcvr_test.sv
`timescale 1ns/1ps
module regbus_xcvr_test;
   localparam int W = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
   logic         oe_n = 1'b1, dir = 1'b0, sel_b_src = 1'b0, sel_a_src = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;

   regbus_xcvr #(.WIDTH(W)) uut (
      .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
      .sel_b_src(sel_b_src), .sel_a_src(sel_a_src), .a_in(a_in), .b_in(b_in),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   int errors = 0;
   int checks = 0;
   logic [W-1:0] m_ra = '0, m_rb = '0;   // bench model of the two registers
   int cycles = 0;
   bit finished = 0;

   task automatic check_port(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // full-port comparison against the bench model
   task automatic check_all(string req);
      logic [W-1:0] ea_out, eb_out, ea_oe, eb_oe;
      ea_oe  = (!oe_n && !dir) ? '1 : '0;
      eb_oe  = (!oe_n &&  dir) ? '1 : '0;
      eb_out = (!oe_n &&  dir) ? ~(sel_b_src ? m_ra : a_in) : '0;
      ea_out = (!oe_n && !dir) ? ~(sel_a_src ? m_rb : b_in) : '0;
      #2;
      check_port(req, "a_out", a_out, ea_out);
      check_port(req, "a_oe",  a_oe,  ea_oe);
      check_port(req, "b_out", b_out, eb_out);
      check_port(req, "b_oe",  b_oe,  eb_oe);
   endtask

   task automatic pulse(bit pa, bit pb);
      #3;
      clk_a = pa; clk_b = pb;
      if (pa) m_ra = a_in;
      if (pb) m_rb = b_in;
      #4;
      clk_a = 1'b0; clk_b = 1'b0;
      #3;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; oe_n = 1'b0; dir = 1'b1; sel_b_src = 1'b1; sel_a_src = 1'b1;
      a_in = 8'h5A; b_in = 8'hC3;
      m_ra = '0; m_rb = '0;
      check_all("R9");
      #5 rst_n = 1'b1;
      check_all("R9");
      dir = 1'b0;
      check_all("R9");
   endtask

   task automatic t_truth_table();
      for (int i = 0; i < 16; i++) begin
         oe_n = i[3]; dir = i[2]; sel_b_src = i[1]; sel_a_src = i[0];
         a_in = 8'h11 * i[3:0] ^ 8'hA5;
         b_in = 8'h1D + 8'h07 * i[3:0];
         check_all(oe_n ? "R3" : (sel_b_src | sel_a_src) ? "R7" : "R6");
      end
      // R4 R5 R10: toggle the idle side's select, outputs must not move
      oe_n = 1'b0; dir = 1'b1; sel_b_src = 1'b0;
      a_in = 8'h3C; b_in = 8'h81;
      sel_a_src = 1'b0; check_all("R10");
      sel_a_src = 1'b1; check_all("R10");
      dir = 1'b0; sel_a_src = 1'b0;
      sel_b_src = 1'b1; check_all("R10");
      sel_b_src = 1'b0; check_all("R4");
   endtask

   task automatic t_capture_isolated();
      oe_n = 1'b1; dir = 1'b1;
      a_in = 8'hE7; b_in = 8'h42;
      pulse(1, 1);
      check_all("R2");
      oe_n = 1'b0; sel_b_src = 1'b1; a_in = 8'h00;
      check_all("R2");
      dir = 1'b0; sel_a_src = 1'b1; b_in = 8'hFF;
      check_all("R2");
   endtask

   task automatic t_simultaneous();
      oe_n = 1'b0; sel_a_src = 1'b1; sel_b_src = 1'b1;
      a_in = 8'h96; b_in = 8'h69;
      pulse(1, 1);
      a_in = 8'h01; b_in = 8'h02;
      dir = 1'b1; check_all("R1");
      dir = 1'b0; check_all("R1");
   endtask

   task automatic t_staggered();
      oe_n = 1'b0; sel_a_src = 1'b1; sel_b_src = 1'b1;
      a_in = 8'hAA; b_in = 8'h55;
      pulse(1, 0);
      dir = 1'b1; check_all("R1");
      dir = 1'b0; check_all("R1");
      a_in = 8'h0F; b_in = 8'hF0;
      pulse(0, 1);
      dir = 1'b1; check_all("R1");
      dir = 1'b0; check_all("R1");
   endtask

   task automatic t_stored_update();
      oe_n = 1'b0; dir = 1'b1; sel_b_src = 1'b1;
      a_in = 8'h7E;
      pulse(1, 0);
      check_all("R8");
      dir = 1'b0; sel_a_src = 1'b1;
      b_in = 8'hB4;
      pulse(0, 1);
      check_all("R8");
      b_in = 8'h11;
      check_all("R7");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected<=200000", cycles);
         finish_run();
      end
   end

   initial begin
      t_reset();
      t_truth_table();
      t_capture_isolated();
      t_simultaneous();
      t_staggered();
      t_stored_update();
      finish_run();
   end
endmodule